// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block keeps frame timing for a full-speed USB host controller. Software programs a frame interval register that holds three things: the spacing between start-of-frame events in bit times, a largest-data-packet budget, and a toggle bit. A 14-bit remaining counter counts bit times down within the current frame. When the counter reaches zero it reloads from the interval and emits a start-of-frame strobe. The same strobe reloads a separate budget down counter. A scheduler can read that counter to decide whether a transaction still fits in the frame.

Counting advances only on cycles where the bit-time enable is high, and only while the run input is asserted. When run rises, the timer starts a fresh frame at once. The remaining register carries a copy of the interval toggle, taken at each reload. Software can compare the two toggles to see whether a newly written interval is in force yet. Both registers are read through one address-selected port. Only the interval register accepts writes.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, address 0 reads 0x00002EDF (interval 11,999, budget 0, toggle 0), address 1 reads 0, and the start-of-frame strobe is low.
- R2: A write to address 0 stores bit 31 as the interval toggle, bits 30:16 as the packet budget and bits 13:0 as the interval. Bits 15:14 always read 0, whatever was written to them.
- R3: Address 1 reads the remaining toggle in bit 31 and the remaining count in bits 13:0, with every other bit 0. Writes to address 1 change nothing.
- R4: In the cycle where run_en is high and was low in the cycle before, the start-of-frame strobe is high. After that edge, the remaining count equals the interval and the budget count equals the budget field.
- R5: While running, each cycle with bit_tick high and no strobe lowers the remaining count by one. A cycle with bit_tick low leaves it unchanged.
- R6: While running, a cycle with bit_tick high and remaining count 0 raises the strobe for that one cycle, and the count reloads with the interval. A frame therefore spans interval+1 bit ticks.
- R7: The budget count loads the budget field at every strobe. It decrements once per running bit tick and holds at 0 instead of wrapping.
- R8: At every reload the remaining toggle takes the interval toggle. An interval written mid-frame leaves the current count and the remaining toggle untouched until the next reload.
- R9: While run_en is low, both counters hold and the strobe stays low, even if bit_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 interval, 1 remaining |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| run_en | input | 1 | Run enable; its rising edge starts a frame |
| bit_tick | input | 1 | One full-speed bit time has elapsed |
| sof_pulse | output | 1 | Start-of-frame strobe, one cycle wide |
| remain_cnt | output | 14 | Bit times left in the current frame |
| budget_cnt | output | 15 | Largest-data-packet counter in bits |

## Verification
The properties assume that run_en, bit_tick and the write port are synchronous to clk and hold known values from reset release onward. The bench drives every input on the falling edge and samples half a cycle later, so each rising edge sees stable values. The properties also rely on one ordering: an interval write in the same cycle as a reload does not affect that reload, which picks up the value held before the edge. The bench keeps its mid-frame interval write well clear of any reload, so it can observe the deferred effect on its own.

// File: rtl/usbft_pkg.sv
`timescale 1ns/1ps
package usbft_pkg;
   localparam int REG_W   = 32;
   localparam int TOG_BIT = 31;
   localparam int BUD_LSB = 16;

   typedef enum logic {
      FT_SEL_INTV   = 1'b0,
      FT_SEL_REMAIN = 1'b1
   } ft_sel_e;
endpackage

// File: rtl/ft_intv_reg.sv
`timescale 1ns/1ps
module ft_intv_reg #(
   parameter int CNT_W    = 14,
   parameter int BUD_W    = 15,
   parameter int NOM_INTV = 11999
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [usbft_pkg::REG_W-1:0] wdata,
   output logic                    tog_q,
   output logic [BUD_W-1:0]        bud_q,
   output logic [CNT_W-1:0]        val_q
);
   import usbft_pkg::*;

   localparam logic [CNT_W-1:0] NOM_V = CNT_W'(NOM_INTV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         bud_q <= '0;
         val_q <= NOM_V;
      end else if (wr_en) begin
         tog_q <= wdata[TOG_BIT];
         bud_q <= wdata[BUD_LSB +: BUD_W];
         val_q <= wdata[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/ft_remain_ctr.sv
`timescale 1ns/1ps
module ft_remain_ctr #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             bit_tick,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_tog,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tog_q,
   output logic             sof
);
   logic run_q;
   logic at_zero;

   assign at_zero = (cnt_q == '0);
   assign sof     = run_en && (!run_q || (bit_tick && at_zero));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else begin
         run_q <= run_en;
         if (sof) begin
            cnt_q <= load_val;
            tog_q <= load_tog;
         end else if (run_en && bit_tick) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ft_budget_ctr.sv
`timescale 1ns/1ps
module ft_budget_ctr #(
   parameter int BUD_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             dec,
   input  logic [BUD_W-1:0] load_val,
   output logic [BUD_W-1:0] cnt_q
);
   logic floor;
   assign floor = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && !floor)
         cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/usb_frame_timer.sv
`timescale 1ns/1ps
module usb_frame_timer #(
   parameter int CNT_W    = 14,
   parameter int BUD_W    = 15,
   parameter int NOM_INTV = 11999
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              run_en,
   input  logic              bit_tick,
   output logic              sof_pulse,
   output logic [CNT_W-1:0]  remain_cnt,
   output logic [BUD_W-1:0]  budget_cnt
);
   import usbft_pkg::*;

   if (CNT_W < 1 || CNT_W > BUD_LSB) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..%0d", BUD_LSB);
   end
   if (BUD_W < 1 || BUD_LSB + BUD_W > TOG_BIT) begin : g_bad_bud_w
      $error("budget field overlaps the toggle bit");
   end
   if (NOM_INTV < 0 || NOM_INTV >= (1 << CNT_W)) begin : g_bad_nom
      $error("NOM_INTV does not fit in CNT_W bits");
   end

   ft_sel_e          sel;
   logic             intv_wr;
   logic             intv_tog;
   logic [BUD_W-1:0] intv_bud;
   logic [CNT_W-1:0] intv_val;
   logic             rem_tog;

   assign sel     = ft_sel_e'(reg_addr);
   assign intv_wr = reg_we && (sel == FT_SEL_INTV);

   ft_intv_reg #(.CNT_W(CNT_W), .BUD_W(BUD_W), .NOM_INTV(NOM_INTV)) u_intv (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (intv_wr),
      .wdata (reg_wdata),
      .tog_q (intv_tog),
      .bud_q (intv_bud),
      .val_q (intv_val)
   );

   ft_remain_ctr #(.CNT_W(CNT_W)) u_remain (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .bit_tick (bit_tick),
      .load_val (intv_val),
      .load_tog (intv_tog),
      .cnt_q    (remain_cnt),
      .tog_q    (rem_tog),
      .sof      (sof_pulse)
   );

   ft_budget_ctr #(.BUD_W(BUD_W)) u_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sof_pulse),
      .dec      (run_en && bit_tick),
      .load_val (intv_bud),
      .cnt_q    (budget_cnt)
   );

   always_comb begin
      reg_rdata = '0;
      if (sel == FT_SEL_INTV) begin
         reg_rdata[TOG_BIT]            = intv_tog;
         reg_rdata[BUD_LSB +: BUD_W]   = intv_bud;
         reg_rdata[CNT_W-1:0]          = intv_val;
      end else begin
         reg_rdata[TOG_BIT]            = rem_tog;
         reg_rdata[CNT_W-1:0]          = remain_cnt;
      end
   end
endmodule

// File: rtl/ft_chk.sv
`timescale 1ns/1ps
module ft_chk #(
   parameter int CNT_W = 14,
   parameter int BUD_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             bit_tick,
   input logic             sof_pulse,
   input logic [CNT_W-1:0] remain_cnt,
   input logic [BUD_W-1:0] budget_cnt,
   input logic [CNT_W-1:0] intv_val,
   input logic [BUD_W-1:0] intv_bud,
   input logic             intv_tog,
   input logic             rem_tog
);
   p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> remain_cnt == $past(intv_val));

   p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && bit_tick && !sof_pulse) |=> remain_cnt == CNT_W'($past(remain_cnt) - 1'b1));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !bit_tick && !sof_pulse) |=> $stable(remain_cnt));

   p_wrap_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && bit_tick && remain_cnt == '0) |-> sof_pulse);

   p_budget_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> budget_cnt == $past(intv_bud));

   p_budget_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (budget_cnt == '0 && !sof_pulse) |=> budget_cnt == '0);

   p_toggle_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> rem_tog == $past(intv_tog));

   p_toggle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_pulse |=> $stable(rem_tog));

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable(remain_cnt) && $stable(budget_cnt)));

   p_no_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !sof_pulse);
endmodule

bind usb_frame_timer ft_chk #(.CNT_W(CNT_W), .BUD_W(BUD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en     (run_en),
   .bit_tick   (bit_tick),
   .sof_pulse  (sof_pulse),
   .remain_cnt (remain_cnt),
   .budget_cnt (budget_cnt),
   .intv_val   (intv_val),
   .intv_bud   (intv_bud),
   .intv_tog   (intv_tog),
   .rem_tog    (rem_tog)
);

// File: tb/sim_usb_frame_timer.sv
`timescale 1ns/1ps
module sim_usb_frame_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        run_en = 1'b0;
   logic        bit_tick = 1'b0;
   logic        sof_pulse;
   logic [13:0] remain_cnt;
   logic [14:0] budget_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   usb_frame_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_en(run_en),
      .bit_tick(bit_tick), .sof_pulse(sof_pulse), .remain_cnt(remain_cnt),
      .budget_cnt(budget_cnt)
   );

   // {address, write data, expected read-back at that address}
   localparam logic [64:0] VEC [4] = '{
      {1'b0, 32'hFFFF_FFFF, 32'hFFFF_3FFF},  // R2 reserved 15:14 read zero
      {1'b0, 32'h8005_0064, 32'h8005_0064},  // R2 toggle, budget, interval
      {1'b0, 32'h0003_C00A, 32'h0003_000A},  // R2 reserved write dropped
      {1'b1, 32'hFFFF_FFFF, 32'h0000_0000}   // R3 remaining not writable
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(1'b0, r); chk("R1 interval reset", r, 32'h0000_2EDF);
      rd(1'b1, r); chk("R1 remaining reset", r, 32'h0);
      chk("R1 sof idle", 32'(sof_pulse), 32'h0);

      for (int i = 0; i < 4; i++) begin
         wr(VEC[i][64], VEC[i][63:32]);
         rd(VEC[i][64], r);
         chk(VEC[i][64] ? "R3 table" : "R2 table", r, VEC[i][31:0]);
      end

      // interval 5, budget 3, toggle 1
      wr(1'b0, 32'h8003_0005);
      run_en = 1'b1;
      #1 chk("R4 sof on run rise", 32'(sof_pulse), 32'h1);
      step();
      #1 chk("R4 sof one cycle", 32'(sof_pulse), 32'h0);
      chk("R4 remain loaded", 32'(remain_cnt), 32'd5);
      chk("R4 budget loaded", 32'(budget_cnt), 32'd3);
      rd(1'b1, r); chk("R3 remain layout", r, 32'h8000_0005);
      step();
      chk("R5 hold without tick", 32'(remain_cnt), 32'd5);

      bit_tick = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         step();
         chk("R5 decrement", 32'(remain_cnt), 32'(5 - k));
         chk("R7 budget dec/saturate", 32'(budget_cnt), 32'((k >= 3) ? 0 : 3 - k));
      end
      #1 chk("R6 sof at zero", 32'(sof_pulse), 32'h1);
      step();
      chk("R6 reload interval", 32'(remain_cnt), 32'd5);
      chk("R7 budget reload", 32'(budget_cnt), 32'd3);

      run_en = 1'b0;
      #1 chk("R9 no sof when stopped", 32'(sof_pulse), 32'h0);
      repeat (3) step();
      chk("R9 remain frozen", 32'(remain_cnt), 32'd5);
      chk("R9 budget frozen", 32'(budget_cnt), 32'd3);

      bit_tick = 1'b0;
      run_en = 1'b1;
      step();
      bit_tick = 1'b1;
      step();
      bit_tick = 1'b0;
      chk("R5 count after restart", 32'(remain_cnt), 32'd4);
      wr(1'b0, 32'h0002_0007);
      rd(1'b1, r); chk("R8 deferred interval", r, 32'h8000_0004);
      bit_tick = 1'b1;
      repeat (4) step();
      #1 chk("R6 sof second frame", 32'(sof_pulse), 32'h1);
      step();
      rd(1'b1, r); chk("R8 toggle copied at reload", r, 32'h0000_0007);
      chk("R7 new budget", 32'(budget_cnt), 32'd2);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         #1000000;
      join_any
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule